// File: doc/BRIEF.md
# Call Gate Transfer Sequencer

This block carries out a far call that passes through a gate entry held in a descriptor table. The caller supplies a selector and its current privilege level. The offset that comes with the call is not used. The sequencer fetches the 64-bit gate entry that the selector names and checks its type, its present bit and its privilege against the caller. It then fetches the code-segment descriptor that the gate's destination selector names. It checks that this segment does not lower privilege and that the gate offset lies within the segment limit. Finally it adds the gate offset to the segment base to form the linear entry address.

Descriptor reads go through a plain request/response port. The block holds `mem_req` high with a steady address until `mem_rvalid` arrives, so any number of wait cycles is allowed. At the end, a one-cycle `done` pulse delivers either the entry address together with the new privilege level and the new code selector, or a fault code. The results stay on the outputs until the next accepted call. Stack switching, parameter copying and returns are handled elsewhere.

Top module: `callgate_seq`

## Requirements
- R1: After synchronous reset the outputs are `busy`=0, `done`=0, `fault`=0, `mem_req`=0, `fault_code`=0, `entry_addr`=0, `new_pl`=0 and `new_cs`=0.
- R2: When `start` is seen while idle, `mem_req` rises on the next cycle with `mem_addr` = `call_sel[15:2]` (table bit and index). `call_off` has no effect on any result.
- R3: While `mem_req` is high and `mem_rvalid` is low, `mem_req` stays high and `mem_addr` stays unchanged. A read completes on the first cycle with `mem_rvalid` high.
- R4: Gate entry layout: offset [31:0], destination selector [47:32], type [51:48] (a call gate is 4'hC), level [53:52], present [54]. Gate checks in priority order: wrong type gives fault code 1, present clear gives code 2, caller level numerically above the gate level gives code 3. After a gate fault no second read is made.
- R5: The second read uses `mem_addr` = destination selector bits [15:2] taken from the gate.
- R6: Target descriptor layout: base [31:0], limit [51:32], level [53:52]. A target level numerically above the caller level gives code 4. Otherwise a gate offset above the limit gives code 5. An offset equal to the limit is accepted.
- R7: On success `entry_addr` = base + gate offset modulo 2^32, `new_pl` = target level, `new_cs` = {destination selector[15:2], target level}, and `fault_code` = 0.
- R8: `done` is high for exactly one cycle per call, and `fault` is high only together with `done`. On a fault `new_pl` returns the caller level and `entry_addr` and `new_cs` are 0. All results hold until the next accepted call.
- R9: `start` while busy (from acceptance through the `done` cycle) is ignored and does not change the running call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a call when idle |
| call_sel | input | 16 | Selector naming the gate entry |
| call_off | input | 32 | Offset supplied with the call (unused) |
| cur_pl | input | 2 | Caller's current privilege level |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 14 | Descriptor entry address (table bit and index) |
| mem_rdata | input | 64 | Descriptor read data |
| mem_rvalid | input | 1 | Read data valid |
| busy | output | 1 | A call is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion was a fault |
| fault_code | output | 3 | 0 none, 1 gate type, 2 gate absent, 3 gate privilege, 4 target privilege, 5 limit |
| entry_addr | output | 32 | Linear entry address |
| new_pl | output | 2 | Privilege level after the call |
| new_cs | output | 16 | New code selector |

## Verification
Successful calls run at several caller and target levels, with zero and multi-cycle memory latency and with differing call offsets. These runs separate the correct indirect addressing from any use of the call offset, and they show that the address is held while a read waits. Each fault is triggered alone and then in pairs, which pins down the priority order, and the read count and read addresses show whether the target was fetched after a gate fault. Edge values mark the exact comparison boundaries: offset equal to the limit and one past it, target level equal to the caller and one above it, caller level equal to the gate and one above it, and a base plus offset that wraps past 2^32. A start pulse during a running call checks that the running call is left undisturbed.

// File: rtl/cg_pkg.sv
package cg_pkg;

    localparam int SEL_W   = 16;
    localparam int OFF_W   = 32;
    localparam int LIM_W   = 20;
    localparam int PL_W    = 2;
    localparam int TYPE_W  = 4;
    localparam int DESC_W  = 64;
    localparam int MADDR_W = SEL_W - 2;
    localparam int GRSV_W  = DESC_W - 1 - PL_W - TYPE_W - SEL_W - OFF_W;
    localparam int TRSV_W  = DESC_W - PL_W - LIM_W - OFF_W;

    localparam logic [TYPE_W-1:0] CALL_GATE_TYPE = 4'hC;

    typedef struct packed {
        logic [GRSV_W-1:0] rsvd;
        logic              present;
        logic [PL_W-1:0]   lvl;
        logic [TYPE_W-1:0] kind;
        logic [SEL_W-1:0]  dsel;
        logic [OFF_W-1:0]  off;
    } gate_t;

    typedef struct packed {
        logic [TRSV_W-1:0] rsvd;
        logic [PL_W-1:0]   lvl;
        logic [LIM_W-1:0]  limit;
        logic [OFF_W-1:0]  base;
    } target_t;

    typedef enum logic [2:0] {
        FLT_NONE        = 3'd0,
        FLT_GATE_TYPE   = 3'd1,
        FLT_GATE_ABSENT = 3'd2,
        FLT_GATE_PRIV   = 3'd3,
        FLT_TGT_PRIV    = 3'd4,
        FLT_TGT_LIMIT   = 3'd5
    } fault_e;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_GATE, S_CHK_GATE, S_RD_TGT, S_CHK_TGT, S_DONE, S_FAULT
    } state_e;

    typedef struct packed {
        logic [OFF_W-1:0] entry;
        logic [PL_W-1:0]  pl;
        logic [SEL_W-1:0] cs;
        fault_e           code;
    } result_t;

    function automatic logic [MADDR_W-1:0] sel_to_addr(input logic [SEL_W-1:0] s);
        return s[SEL_W-1:2];
    endfunction

endpackage

// File: rtl/cg_gate_check.sv
module cg_gate_check
    import cg_pkg::*;
(
    input  gate_t           gate,
    input  logic [PL_W-1:0] caller_pl,
    output fault_e          code
);
    always_comb begin
        if (gate.kind != CALL_GATE_TYPE)
            code = FLT_GATE_TYPE;
        else if (!gate.present)
            code = FLT_GATE_ABSENT;
        else if (caller_pl > gate.lvl)
            code = FLT_GATE_PRIV;
        else
            code = FLT_NONE;
    end
endmodule

// File: rtl/cg_target_check.sv
module cg_target_check
    import cg_pkg::*;
(
    input  target_t          tgt,
    input  logic [OFF_W-1:0] gate_off,
    input  logic [PL_W-1:0]  caller_pl,
    output fault_e           code,
    output logic [OFF_W-1:0] entry
);
    localparam int PAD_W = OFF_W - LIM_W;

    logic [OFF_W-1:0] limit_ext;
    assign limit_ext = {{PAD_W{1'b0}}, tgt.limit};

    always_comb begin
        if (tgt.lvl > caller_pl)
            code = FLT_TGT_PRIV;
        else if (gate_off > limit_ext)
            code = FLT_TGT_LIMIT;
        else
            code = FLT_NONE;
    end

    assign entry = tgt.base + gate_off;
endmodule

// File: rtl/callgate_seq.sv
module callgate_seq
    import cg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SEL_W-1:0]    call_sel,
    input  logic [OFF_W-1:0]    call_off,
    input  logic [PL_W-1:0]     cur_pl,
    output logic                mem_req,
    output logic [MADDR_W-1:0]  mem_addr,
    input  logic [DESC_W-1:0]   mem_rdata,
    input  logic                mem_rvalid,
    output logic                busy,
    output logic                done,
    output logic                fault,
    output logic [2:0]          fault_code,
    output logic [OFF_W-1:0]    entry_addr,
    output logic [PL_W-1:0]     new_pl,
    output logic [SEL_W-1:0]    new_cs
);
    state_e          state;
    logic [SEL_W-1:0] sel_q;
    logic [PL_W-1:0]  pl_q;
    gate_t            gate_q;
    target_t          tgt_q;
    result_t          res_q;

    fault_e           gate_code;
    fault_e           tgt_code;
    logic [OFF_W-1:0] tgt_entry;

    logic unused_bits;
    assign unused_bits = ^{call_off, sel_q[1:0], gate_q.rsvd, tgt_q.rsvd};

    cg_gate_check u_gchk (
        .gate      (gate_q),
        .caller_pl (pl_q),
        .code      (gate_code)
    );

    cg_target_check u_tchk (
        .tgt       (tgt_q),
        .gate_off  (gate_q.off),
        .caller_pl (pl_q),
        .code      (tgt_code),
        .entry     (tgt_entry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            sel_q  <= '0;
            pl_q   <= '0;
            gate_q <= '0;
            tgt_q  <= '0;
            res_q  <= '{entry: '0, pl: '0, cs: '0, code: FLT_NONE};
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        sel_q <= call_sel;
                        pl_q  <= cur_pl;
                        state <= S_RD_GATE;
                    end
                end
                S_RD_GATE: begin
                    if (mem_rvalid) begin
                        gate_q <= gate_t'(mem_rdata);
                        state  <= S_CHK_GATE;
                    end
                end
                S_CHK_GATE: begin
                    if (gate_code != FLT_NONE) begin
                        res_q <= '{entry: '0, pl: pl_q, cs: '0, code: gate_code};
                        state <= S_FAULT;
                    end else begin
                        state <= S_RD_TGT;
                    end
                end
                S_RD_TGT: begin
                    if (mem_rvalid) begin
                        tgt_q <= target_t'(mem_rdata);
                        state <= S_CHK_TGT;
                    end
                end
                S_CHK_TGT: begin
                    if (tgt_code != FLT_NONE) begin
                        res_q <= '{entry: '0, pl: pl_q, cs: '0, code: tgt_code};
                        state <= S_FAULT;
                    end else begin
                        res_q <= '{entry: tgt_entry, pl: tgt_q.lvl,
                                   cs: {gate_q.dsel[SEL_W-1:2], tgt_q.lvl},
                                   code: FLT_NONE};
                        state <= S_DONE;
                    end
                end
                S_DONE, S_FAULT: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign mem_req    = (state == S_RD_GATE) || (state == S_RD_TGT);
    assign mem_addr   = (state == S_RD_TGT) ? sel_to_addr(gate_q.dsel) : sel_to_addr(sel_q);
    assign busy       = (state != S_IDLE);
    assign done       = (state == S_DONE) || (state == S_FAULT);
    assign fault      = (state == S_FAULT);
    assign fault_code = res_q.code;
    assign entry_addr = res_q.entry;
    assign new_pl     = res_q.pl;
    assign new_cs     = res_q.cs;
endmodule

// File: rtl/callgate_seq_chk.sv
module callgate_seq_chk
    import cg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [PL_W-1:0]    cur_pl,
    input logic               busy,
    input logic               done,
    input logic               fault,
    input logic [2:0]         fault_code,
    input logic               mem_req,
    input logic [MADDR_W-1:0] mem_addr,
    input logic               mem_rvalid,
    input logic [PL_W-1:0]    new_pl
);
    logic [PL_W-1:0] caller_q;

    always_ff @(posedge clk) begin
        if (rst)
            caller_q <= '0;
        else if (start && !busy)
            caller_q <= cur_pl;
    end

    a_r2_start_req: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> mem_req);

    a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_fault_in_done: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    a_r8_code_agrees: assert property (@(posedge clk) disable iff (rst)
        done |-> (fault == (fault_code != 3'd0)));

    a_r6_no_lowering: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (new_pl <= caller_q));

    a_r9_req_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
endmodule

bind callgate_seq callgate_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cur_pl     (cur_pl),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .new_pl     (new_pl)
);

// File: tb/sim_callgate_seq.sv
`timescale 1ns/1ps
module sim_callgate_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] call_sel = '0;
    logic [31:0] call_off = '0;
    logic [1:0]  cur_pl = '0;
    logic        mem_req;
    logic [13:0] mem_addr;
    logic [63:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        busy, done, fault;
    logic [2:0]  fault_code;
    logic [31:0] entry_addr;
    logic [1:0]  new_pl;
    logic [15:0] new_cs;

    always #2 clk = ~clk;

    callgate_seq u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    int lat = 0;
    int wcnt = 0;
    int nreads = 0;
    int addr_log [2];
    logic [63:0] mem [int];

    logic [31:0] r_entry;
    logic [1:0]  r_pl;
    logic [15:0] r_cs;
    logic [2:0]  r_code;
    logic        r_fault;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (mem_req && !mem_rvalid) begin
            if (wcnt >= lat) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 64'h0;
                if (nreads < 2) addr_log[nreads] = int'(mem_addr);
                nreads++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end else begin
            mem_rvalid <= 1'b0;
            wcnt = 0;
        end
    end

    function automatic logic [63:0] mk_gate(input logic [31:0] off, input logic [15:0] dsel,
                                            input logic [3:0] kind, input logic [1:0] lvl,
                                            input logic present);
        return {9'h0, present, lvl, kind, dsel, off};
    endfunction

    function automatic logic [63:0] mk_tgt(input logic [31:0] base, input logic [19:0] lim,
                                           input logic [1:0] lvl);
        return {10'h0, lvl, lim, base};
    endfunction

    task automatic do_call(input logic [15:0] sel, input logic [31:0] off, input logic [1:0] pl);
        int waitc;
        nreads = 0;
        addr_log[0] = -1;
        addr_log[1] = -1;
        @(negedge clk);
        call_sel = sel; call_off = off; cur_pl = pl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waitc = 0;
        while (!done && waitc < 1000) begin
            @(negedge clk);
            waitc++;
        end
        if (!done) check("R8 done seen", 0, 1);
        r_entry = entry_addr; r_pl = new_pl; r_cs = new_cs;
        r_code = fault_code; r_fault = fault;
    endtask

    localparam logic [15:0] GSEL = 16'h0028;
    localparam logic [15:0] DSEL = 16'h004B;
    localparam int GADDR = 16'h0028 >> 2;
    localparam int DADDR = 16'h004B >> 2;

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 fault", fault, 0);
        check("R1 mem_req", mem_req, 0);
        check("R1 code", fault_code, 0);
        check("R1 outputs", {entry_addr, new_pl, new_cs}, 0);
    endtask

    task automatic t_success();
        mem[GADDR] = mk_gate(32'h1234, DSEL, 4'hC, 2'd3, 1'b1);
        mem[DADDR] = mk_tgt(32'h0010_0000, 20'h0FFFF, 2'd0);
        do_call(GSEL, 32'hDEAD_BEEF, 2'd3);
        check("R7 entry", r_entry, 32'h0010_1234);
        check("R7 new_pl", r_pl, 0);
        check("R7 new_cs", r_cs, 16'h0048);
        check("R7 code", {r_fault, r_code}, 0);
        check("R2 gate read addr", addr_log[0], GADDR);
        check("R5 target read addr", addr_log[1], DADDR);
        check("R5 reads", nreads, 2);
        do_call(GSEL, 32'h0000_0007, 2'd3);
        check("R2 call_off ignored", r_entry, 32'h0010_1234);
    endtask

    task automatic t_latency();
        lat = 3;
        do_call(GSEL, 32'h0, 2'd2);
        check("R3 waited entry", r_entry, 32'h0010_1234);
        check("R3 waited reads", nreads, 2);
        lat = 0;
    endtask

    task automatic t_gate_faults();
        mem[GADDR] = mk_gate(32'h10, DSEL, 4'h4, 2'd3, 1'b1);
        do_call(GSEL, 0, 2'd0);
        check("R4 type fault", {r_fault, r_code}, {1'b1, 3'd1});
        check("R4 no target read", nreads, 1);
        check("R8 fault outputs", {r_entry, r_pl, r_cs}, {32'h0, 2'd0, 16'h0});
        mem[GADDR] = mk_gate(32'h10, DSEL, 4'hC, 2'd3, 1'b0);
        do_call(GSEL, 0, 2'd1);
        check("R4 absent fault", r_code, 3'd2);
        check("R8 fault keeps caller pl", r_pl, 2'd1);
        mem[GADDR] = mk_gate(32'h10, DSEL, 4'hC, 2'd2, 1'b1);
        do_call(GSEL, 0, 2'd3);
        check("R4 priv fault", r_code, 3'd3);
        check("R4 priv no target read", nreads, 1);
        do_call(GSEL, 0, 2'd2);
        check("R4 equal level ok", {r_fault, r_code}, 0);
        mem[GADDR] = mk_gate(32'h10, DSEL, 4'h4, 2'd0, 1'b0);
        do_call(GSEL, 0, 2'd3);
        check("R4 type over absent", r_code, 3'd1);
        mem[GADDR] = mk_gate(32'h10, DSEL, 4'hC, 2'd0, 1'b0);
        do_call(GSEL, 0, 2'd3);
        check("R4 absent over priv", r_code, 3'd2);
    endtask

    task automatic t_target_faults();
        mem[GADDR] = mk_gate(32'h100, DSEL, 4'hC, 2'd3, 1'b1);
        mem[DADDR] = mk_tgt(32'h2000, 20'h100, 2'd2);
        do_call(GSEL, 0, 2'd1);
        check("R6 target priv fault", r_code, 3'd4);
        mem[DADDR] = mk_tgt(32'h2000, 20'h100, 2'd1);
        do_call(GSEL, 0, 2'd1);
        check("R6 offset at limit ok", {r_fault, r_code}, 0);
        check("R7 same level entry", r_entry, 32'h2100);
        check("R7 same level pl", r_pl, 2'd1);
        mem[GADDR] = mk_gate(32'h101, DSEL, 4'hC, 2'd3, 1'b1);
        do_call(GSEL, 0, 2'd1);
        check("R6 limit fault", r_code, 3'd5);
        mem[DADDR] = mk_tgt(32'h2000, 20'h100, 2'd2);
        do_call(GSEL, 0, 2'd1);
        check("R6 priv over limit", r_code, 3'd4);
    endtask

    task automatic t_wrap();
        mem[GADDR] = mk_gate(32'h20, DSEL, 4'hC, 2'd3, 1'b1);
        mem[DADDR] = mk_tgt(32'hFFFF_FFF0, 20'hFFFFF, 2'd0);
        do_call(GSEL, 0, 2'd0);
        check("R7 wrap entry", r_entry, 32'h0000_0010);
    endtask

    task automatic t_busy_start();
        int waitc;
        lat = 2;
        mem[GADDR] = mk_gate(32'h44, DSEL, 4'hC, 2'd3, 1'b1);
        mem[DADDR] = mk_tgt(32'h5000, 20'hFFF, 2'd0);
        mem[16'h0080 >> 2] = mk_gate(32'h99, DSEL, 4'h4, 2'd3, 1'b1);
        nreads = 0;
        @(negedge clk);
        call_sel = GSEL; cur_pl = 2'd3; start = 1'b1;
        @(negedge clk);
        call_sel = 16'h0080; cur_pl = 2'd0;
        repeat (3) @(negedge clk);
        start = 1'b0;
        waitc = 0;
        while (!done && waitc < 1000) begin
            @(negedge clk);
            waitc++;
        end
        check("R9 running call kept", {fault, fault_code, entry_addr}, {1'b0, 3'd0, 32'h5044});
        check("R9 reads", nreads, 2);
        @(negedge clk);
        check("R8 done one cycle", done, 0);
        check("R8 results held", {entry_addr, new_pl}, {32'h5044, 2'd0});
        lat = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_success();
        t_latency();
        t_gate_faults();
        t_target_faults();
        t_wrap();
        t_busy_start();
        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule